// File: doc/BRIEF.md
# Translation Buffer Entry Pointer Generator

After a translation lookaside miss, software or a hardware walker needs the memory address of the entry to probe in the in-memory translation storage buffer. This block turns the captured miss information (a 64-bit tag-access word holding the virtual page above bit 12 and the context number in bits 12:0) into that address. It does this for either of two page-size classes. It also produces the tag-target word that is compared against the stored entry.

Two register sets feed the block: one for context zero and one for all other contexts. Each set has a base register per page-size class and one configuration register. The context field picks the set and the class input picks the base. The base supplies the upper pointer bits, a buffer-size code and a split flag. The configuration register supplies the page-size code for the class. The virtual address is shifted by the page size and masked to the buffer size to form the entry index. The logic is combinational, and a parameter adds one output register stage, which is enabled by default.

Top module: `tsb_ptr_gen`

## Requirements
- R1: When `tag_access_i[12:0]` is zero, the context-zero base and configuration registers are used. Any other value selects the nonzero-context registers. `cls_i` = 0 picks the class-0 base and `cls_i` = 1 picks the class-1 base.
- R2: Every set bit in bits 63:13 of the selected base also appears in the pointer. Only the index and split bits are ORed on top of them.
- R3: The page-size code comes from configuration bits 2:0 for class 0 and from bits 10:8 for class 1.
- R4: When class 1 is selected and base bit 12 (the split flag) is set, pointer bit (13 + S) is set, where S is base bits 3:0. The split flag has no effect for class 0.
- R5: The index equals the tag-access word shifted right by (9 + 3·P), where P is the page-size code. It is masked to bits 4 through (12 + S) and ORed into the pointer.
- R6: Pointer bits 3:0 are always zero.
- R7: Tag-target bits 41:0 equal tag-access bits 63:22 and bits 60:48 equal tag-access bits 12:0. All other bits are zero.
- R8: With the output register enabled (the default), both outputs reflect the inputs of the previous rising edge. While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| tag_access_i | input | 64 | Virtual page (63:13) and context (12:0) of the miss |
| cls_i | input | 1 | Page-size class select, 0 or 1 |
| z_base_c0_i | input | 64 | Context-zero base, class 0 |
| z_base_c1_i | input | 64 | Context-zero base, class 1 |
| n_base_c0_i | input | 64 | Nonzero-context base, class 0 |
| n_base_c1_i | input | 64 | Nonzero-context base, class 1 |
| z_cfg_i | input | 64 | Context-zero page-size configuration |
| n_cfg_i | input | 64 | Nonzero-context page-size configuration |
| ptr_o | output | 64 | Entry pointer |
| tag_tgt_o | output | 64 | Tag-target word |

## Verification
The only state is the output register, so a wrong internal value shows at the ports one edge after the inputs that caused it. A wrong register-set or class choice shows up when the two sets carry different bases and configurations. Those tests show the wrong base bits, the wrong buffer size or the wrong shift directly in `ptr_o`. Errors in the split-bit and mask boundaries are exposed at the extreme size codes, where a one-bit slip sets or drops a pointer bit next to the index field.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
  localparam int unsigned DW         = 64;
  localparam int unsigned CTX_W      = 13;
  localparam int unsigned PG_W       = 3;
  localparam int unsigned SZ_W       = 4;
  localparam int unsigned BASE_LSB   = 13;
  localparam int unsigned SPLIT_POS  = 12;
  localparam int unsigned IDX_LSB    = 4;
  localparam int unsigned SHIFT_BASE = 9;
  localparam int unsigned SHIFT_STEP = 3;
  localparam int unsigned CFG1_LSB   = 8;
  localparam int unsigned TT_VA_LSB  = 22;
  localparam int unsigned TT_CTX_LSB = 48;
  localparam int unsigned TT_VA_W    = DW - TT_VA_LSB;

  typedef logic [DW-1:0]   word_t;
  typedef logic [PG_W-1:0] pg_t;
  typedef logic [SZ_W-1:0] sz_t;

  // Upper bits of the base that pass straight into the pointer
  function automatic word_t base_keep_mask();
    return ~((word_t'(1) << BASE_LSB) - word_t'(1));
  endfunction

  // Mask covering bits IDX_LSB .. (12 + sz)
  function automatic word_t index_mask(sz_t sz);
    int unsigned top;
    top = BASE_LSB + int'(sz);
    return ((word_t'(1) << top) - word_t'(1)) & ~((word_t'(1) << IDX_LSB) - word_t'(1));
  endfunction

  function automatic word_t index_field(word_t tag, pg_t pg, sz_t sz);
    int unsigned sh;
    sh = SHIFT_BASE + SHIFT_STEP * int'(pg);
    return (tag >> sh) & index_mask(sz);
  endfunction

  function automatic word_t split_field(logic cls, logic split, sz_t sz);
    return (cls && split) ? (word_t'(1) << (BASE_LSB + int'(sz))) : '0;
  endfunction

  function automatic word_t tag_target(word_t tag);
    word_t t;
    t = '0;
    t[TT_VA_W-1:0] = tag[DW-1:TT_VA_LSB];
    t[TT_CTX_LSB +: CTX_W] = tag[CTX_W-1:0];
    return t;
  endfunction
endpackage

// File: rtl/tsbp_ctx_select.sv
module tsbp_ctx_select
  import tsbp_pkg::*;
(
  input  word_t tag_i,
  input  logic  cls_i,
  input  word_t z_base_c0_i,
  input  word_t z_base_c1_i,
  input  word_t n_base_c0_i,
  input  word_t n_base_c1_i,
  input  word_t z_cfg_i,
  input  word_t n_cfg_i,
  output logic  ctx_zero_o,
  output word_t base_o,
  output pg_t   pg_o
);
  word_t cfg_w;

  always_comb begin
    ctx_zero_o = (tag_i[CTX_W-1:0] == '0);
    if (ctx_zero_o) begin
      base_o = cls_i ? z_base_c1_i : z_base_c0_i;
      cfg_w  = z_cfg_i;
    end else begin
      base_o = cls_i ? n_base_c1_i : n_base_c0_i;
      cfg_w  = n_cfg_i;
    end
    pg_o = cls_i ? cfg_w[CFG1_LSB +: PG_W] : cfg_w[PG_W-1:0];
  end
endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc
  import tsbp_pkg::*;
(
  input  word_t tag_i,
  input  word_t base_i,
  input  pg_t   pg_i,
  input  logic  cls_i,
  output logic  split_o,
  output sz_t   sz_o,
  output word_t ptr_o
);
  word_t idx_w;
  word_t spl_w;

  always_comb begin
    split_o = base_i[SPLIT_POS];
    sz_o    = base_i[SZ_W-1:0];
    idx_w   = index_field(tag_i, pg_i, sz_o);
    spl_w   = split_field(cls_i, split_o, sz_o);
    ptr_o   = (base_i & base_keep_mask()) | spl_w | idx_w;
  end
endmodule

// File: rtl/tsbp_out_stage.sv
module tsbp_out_stage #(
  parameter int unsigned W   = 128,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end

      // R8: registered output follows the previous edge's input
      a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q_o == $past(d_i));
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsbp_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] tag_access_i,
  input  logic        cls_i,
  input  logic [63:0] z_base_c0_i,
  input  logic [63:0] z_base_c1_i,
  input  logic [63:0] n_base_c0_i,
  input  logic [63:0] n_base_c1_i,
  input  logic [63:0] z_cfg_i,
  input  logic [63:0] n_cfg_i,
  output logic [63:0] ptr_o,
  output logic [63:0] tag_tgt_o
);
  localparam int unsigned OUT_W = 2 * DW;

  logic  ctx_zero_w;
  word_t base_w;
  pg_t   pg_w;
  logic  split_w;
  sz_t   sz_w;
  word_t ptr_w;
  word_t tt_w;

  tsbp_ctx_select u_sel (
    .tag_i       (tag_access_i),
    .cls_i       (cls_i),
    .z_base_c0_i (z_base_c0_i),
    .z_base_c1_i (z_base_c1_i),
    .n_base_c0_i (n_base_c0_i),
    .n_base_c1_i (n_base_c1_i),
    .z_cfg_i     (z_cfg_i),
    .n_cfg_i     (n_cfg_i),
    .ctx_zero_o  (ctx_zero_w),
    .base_o      (base_w),
    .pg_o        (pg_w)
  );

  tsbp_ptr_calc u_calc (
    .tag_i   (tag_access_i),
    .base_i  (base_w),
    .pg_i    (pg_w),
    .cls_i   (cls_i),
    .split_o (split_w),
    .sz_o    (sz_w),
    .ptr_o   (ptr_w)
  );

  assign tt_w = tag_target(tag_access_i);

  tsbp_out_stage #(.W(OUT_W), .REG(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({tt_w, ptr_w}),
    .q_o   ({tag_tgt_o, ptr_o})
  );

  // R1: context field at the port decides the register set
  a_r1_zero_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_access_i[12:0] == 13'd0) |-> (ctx_zero_w &&
      base_w == (cls_i ? z_base_c1_i : z_base_c0_i)));
  a_r1_nonzero_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_access_i[12:0] != 13'd0) |-> (!ctx_zero_w &&
      base_w == (cls_i ? n_base_c1_i : n_base_c0_i)));

  // R2: no set upper base bit is lost
  a_r2_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((base_w & base_keep_mask()) & ~ptr_w) == '0);

  // R4: split flag on class 1 sets the offset bit
  a_r4_split_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i && split_w) |-> ptr_w[BASE_LSB + int'(sz_w)]);

  // R6: entry alignment
  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o[3:0] == 4'd0);

  // R7: unused tag-target gaps stay clear
  a_r7_tt_gaps: assert property (@(posedge clk) disable iff (!rst_n)
    tag_tgt_o[47:42] == 6'd0 && tag_tgt_o[63:61] == 3'd0);
endmodule

// File: tb/tsb_ptr_gen_bench.sv
module tsb_ptr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tag = '0;
  logic        cls = 1'b0;
  logic [63:0] zb0 = '0, zb1 = '0, nb0 = '0, nb1 = '0, zc = '0, nc = '0;
  logic [63:0] ptr, tt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsb_ptr_gen u_tsb_ptr_gen (
    .clk(clk), .rst_n(rst_n), .tag_access_i(tag), .cls_i(cls),
    .z_base_c0_i(zb0), .z_base_c1_i(zb1), .n_base_c0_i(nb0), .n_base_c1_i(nb1),
    .z_cfg_i(zc), .n_cfg_i(nc), .ptr_o(ptr), .tag_tgt_o(tt)
  );

  // Independent bit-by-bit model of the pointer
  function automatic logic [63:0] model_ptr();
    logic [63:0] b, c, r;
    int s, p, sh;
    if (tag[12:0] == 13'd0) begin b = cls ? zb1 : zb0; c = zc; end
    else                    begin b = cls ? nb1 : nb0; c = nc; end
    s  = int'(b[3:0]);
    p  = cls ? int'(c[10:8]) : int'(c[2:0]);
    sh = 9 + 3 * p;
    r  = '0;
    for (int i = 4; i < 64; i++) begin
      if (i >= 13 && b[i]) r[i] = 1'b1;
      if (i <= 12 + s && i + sh < 64 && tag[i + sh]) r[i] = 1'b1;
      if (cls && b[12] && i == 13 + s) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [63:0] model_tt();
    return {3'b000, tag[12:0], 6'b000000, tag[63:22]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R8 reset ptr", ptr, 64'd0);
    check("R8 reset tt", tt, 64'd0);
  endtask

  task automatic t_ctx_zero();
    @(negedge clk);
    tag = 64'h0000_1234_5678_0000; cls = 0;
    zb0 = 64'hAAAA_0000_0000_2003; nb0 = 64'h5555_0000_0000_E001;
    zc = 64'h0000_0000_0000_0201; nc = 64'h0000_0000_0000_0003;
    step();
    check("R1 ctx zero ptr", ptr, model_ptr());
    check("R7 ctx zero tt", tt, model_tt());
  endtask

  task automatic t_ctx_nonzero();
    @(negedge clk);
    tag = 64'hDEAD_BEEF_CAFE_0ABC; cls = 0;
    step();
    check("R1 nonzero ctx ptr", ptr, model_ptr());
    check("R7 nonzero ctx tt", tt, model_tt());
  endtask

  task automatic t_class_cfg();
    @(negedge clk);
    tag = 64'h0123_4567_89AB_C000; cls = 1;
    zb1 = 64'h0F00_0000_0000_0005; zc = 64'h0000_0000_0000_0502;
    step();
    check("R3 class1 page code", ptr, model_ptr());
    @(negedge clk); cls = 0;
    step();
    check("R3 class0 page code", ptr, model_ptr());
  endtask

  task automatic t_split();
    @(negedge clk);
    tag = 64'h0; cls = 1; zb1 = 64'h0000_0000_0000_1007; zb0 = 64'h0000_0000_0000_1007;
    step();
    check("R4 split class1", ptr, 64'h0000_0000_0010_0000);
    @(negedge clk); cls = 0;
    step();
    check("R4 split ignored class0", ptr, 64'd0);
  endtask

  task automatic t_index_edges();
    @(negedge clk);
    tag = 64'h0000_0000_0040_0000; cls = 0; zb0 = 64'h0; zc = 64'h0;
    step();
    check("R5 size0 excludes bit13", ptr, 64'd0);
    @(negedge clk); zb0 = 64'h1;
    step();
    check("R5 size1 includes bit13", ptr, 64'h0000_0000_0000_2000);
    @(negedge clk); tag = 64'hFFFF_FFFF_FFFF_FFFF; nb0 = 64'h0000_0000_0000_000F; nc = 64'h7;
    step();
    check("R5 max size max page", ptr, model_ptr());
    check("R6 low bits zero", {60'd0, ptr[3:0]}, 64'd0);
    @(negedge clk); cls = 1; nb1 = 64'h8000_0000_0000_100F; nc = 64'h700;
    step();
    check("R2 base kept split max", ptr, model_ptr());
  endtask

  task automatic t_latency();
    logic [63:0] prev;
    prev = ptr;
    @(negedge clk);
    tag = 64'h0000_0000_0010_0001; cls = 0; nb0 = 64'h0000_0000_0000_4008; nc = 64'h0;
    #1;
    check("R8 holds before edge", ptr, prev);
    step();
    check("R8 updates after edge", ptr, model_ptr());
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 1);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_ctx_zero();
    t_ctx_nonzero();
    t_class_cfg();
    t_split();
    t_index_edges();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule